// File: doc/BRIEF.md
# System Option Register with Write-Once Window

This block holds one 8-bit option register for a small system, together with the two pieces of logic that act on its contents. The first is the conditioning of the active-low external interrupt pin, which can be read as a level or captured on a falling edge. The second is a counter that can hold back the release from a stop mode after a stop-exit request. Software reads and writes the register through a plain register bus. That bus has a select, a write strobe, write data and combinational read data.

Four of the bits set the system up and are protected. In normal mode they take a value only from the first write that lands inside a short window after reset. Once that write is taken, or once the window runs out, they are locked until the next reset. In special mode they can be written at any time. The remaining bits can be written freely at any time. The analog power-up bit, the clock-select bit, the clock-monitor enable and the two watchdog-rate bits leave the block as plain outputs.

Three state machines do the work:
- **Window machine.** It has the states OPEN and CLOSED. OPEN goes to CLOSED on a normal-mode write, or when its cycle count reaches the last cycle of the window. CLOSED is left only by reset.
- **Interrupt machine.** It has the states ARMED and PENDING. ARMED goes to PENDING on a synchronized falling edge while edge mode is on. PENDING goes back to ARMED when the clear input is asserted or edge mode is turned off.
- **Stop-release machine.** It has the states IDLE, COUNT and DONE. A request moves IDLE to COUNT when the delay bit is set, and to DONE when it is not. COUNT goes to DONE after the last count. DONE returns to IDLE. A request arriving in any state starts the sequence again.

Top module: `sysopt_cfg`

## Requirements
- R1: After reset the register reads 0x10. Every option output is 0, irq_req is 0 while the pin is high, and stop_release is 0.
- R2: The register bits are fixed, from bit 7 down to bit 0: analog power-up, clock select, IRQ edge mode, stop delay enable, clock-monitor enable, unused, watchdog rate high, watchdog rate low. reg_rdata shows the register while reg_sel is 1 and 0x00 otherwise. Bit 2 always reads 0.
- R3: Bits 7, 6 and 3 take the written data on every write, in either mode, and drive ana_pwr_o, clk_sel_o and clkmon_en_o. Bits 1:0 drive wdog_rate_o.
- R4: In normal mode, the protected bits (5, 4, 1, 0) accept a write sampled on any of the first WINDOW_CYCLES clock edges after reset is released.
- R5: In normal mode, once one write has been accepted, later writes leave the protected bits unchanged, while the free bits still update.
- R6: In normal mode, writes sampled after the window has expired leave the protected bits unchanged.
- R7: In special mode the protected bits accept every write, whatever has happened since reset.
- R8: With bit 5 at 0, irq_req equals the inverted pin level, delayed by the two synchronizer flops.
- R9: With bit 5 at 1, a falling edge on the pin sets irq_req three cycles later. irq_req then stays set after the pin returns high, until irq_clr clears it on the next edge. A pin held low does not set it again.
- R10: With bit 4 at 0, a stop-exit request produces a one-cycle stop_release pulse in the cycle after the request is sampled.
- R11: With bit 4 at 1, that pulse comes exactly STOP_DELAY cycles later than in the immediate case, and it is still one cycle long.
- R12: A new stop-exit request during the countdown restarts the full delay from that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = protected bits always writable |
| reg_sel | input | 1 | Register address match |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when not selected |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| irq_clr | input | 1 | Clears a latched edge request |
| stop_exit_req | input | 1 | Request to leave stop mode |
| irq_req | output | 1 | Conditioned interrupt request |
| stop_release | output | 1 | One-cycle release pulse |
| ana_pwr_o | output | 1 | Analog power-up bit |
| clk_sel_o | output | 1 | Clock select bit |
| clkmon_en_o | output | 1 | Clock monitor enable bit |
| wdog_rate_o | output | 2 | Watchdog rate select |

## Verification
The bench builds the block with WINDOW_CYCLES = 16 and STOP_DELAY = 40. With the window that short, the last accepted edge and the first rejected edge are each reached a few cycles after reset. With the delay that short, the exact release cycle and a restart part-way through the countdown are checked cycle by cycle without a long run. SYNC_STAGES stays at 2, so the two-cycle level latency and the three-cycle edge latency are checked as written in the requirements.

// File: rtl/sysopt_pkg.sv
`timescale 1ns/1ps
package sysopt_pkg;

    localparam int BIT_ANA     = 7;
    localparam int BIT_CLKSEL  = 6;
    localparam int BIT_EDGE    = 5;
    localparam int BIT_WAIT    = 4;
    localparam int BIT_MON     = 3;
    localparam int BIT_HOLE    = 2;
    localparam int BIT_RATE_HI = 1;
    localparam int BIT_RATE_LO = 0;

    localparam logic [7:0] OPT_RESET = 8'h10;
    localparam logic [7:0] PROT_MASK = 8'h33;
    localparam logic [7:0] FREE_MASK = 8'hC8;

    typedef enum logic {
        WIN_OPEN   = 1'b0,
        WIN_CLOSED = 1'b1
    } win_state_t;

    typedef enum logic {
        IRQ_ARMED   = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_t;

    typedef enum logic [1:0] {
        SD_IDLE  = 2'd0,
        SD_COUNT = 2'd1,
        SD_DONE  = 2'd2
    } stop_state_t;

endpackage

// File: rtl/sysopt_wprot.sv
`timescale 1ns/1ps
module sysopt_wprot
    import sysopt_pkg::*;
#(
    parameter int WINDOW_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic special_mode,
    input  logic wr_hit,
    output logic prot_wr_ok
);

    localparam int WCW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [WCW-1:0] WIN_LAST = WCW'(WINDOW_CYCLES - 1);

    win_state_t     state_q, state_d;
    logic [WCW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_OPEN: begin
                if (wr_hit && !special_mode)
                    state_d = WIN_CLOSED;
                else if (cnt_q == WIN_LAST)
                    state_d = WIN_CLOSED;
            end
            WIN_CLOSED: state_d = WIN_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WIN_OPEN && cnt_q != WIN_LAST)
                cnt_q <= cnt_q + WCW'(1);
        end
    end

    always_comb begin
        prot_wr_ok = special_mode || (state_q == WIN_OPEN);
    end

    AST_WIN_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_CLOSED) |=> (state_q == WIN_CLOSED)); // R6
    AST_WIN_CLOSE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !special_mode) |=> (state_q == WIN_CLOSED)); // R5
    AST_WIN_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= WIN_LAST)); // R4

endmodule

// File: rtl/sysopt_irq_cond.sv
`timescale 1ns/1ps
module sysopt_irq_cond
    import sysopt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic irq_req
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pin_s;
    logic                   fall;
    irq_state_t             state_q, state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= pin_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign pin_s = sync_q[SYNC_STAGES-1];
    assign fall  = prev_q & ~pin_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_ARMED: begin
                if (edge_mode && fall)
                    state_d = IRQ_PENDING;
            end
            IRQ_PENDING: begin
                if (!edge_mode)
                    state_d = IRQ_ARMED;
                else if (clr && !fall)
                    state_d = IRQ_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b1;
            state_q <= IRQ_ARMED;
        end else begin
            prev_q  <= pin_s;
            state_q <= state_d;
        end
    end

    always_comb begin
        if (edge_mode) irq_req = (state_q == IRQ_PENDING);
        else           irq_req = ~pin_s;
    end

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_PENDING && edge_mode && !clr) |=> (state_q == IRQ_PENDING)); // R9
    AST_EDGE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_ARMED && !(prev_q && !pin_s)) |=> (state_q == IRQ_ARMED)); // R9

endmodule

// File: rtl/sysopt_stop_dly.sv
`timescale 1ns/1ps
module sysopt_stop_dly
    import sysopt_pkg::*;
#(
    parameter int STOP_DELAY = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic wait_en,
    output logic release_o
);

    localparam int CW = (STOP_DELAY > 1) ? $clog2(STOP_DELAY) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STOP_DELAY - 1);

    stop_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    stop_state_t   start_st;

    assign start_st = wait_en ? SD_COUNT : SD_DONE;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SD_IDLE: begin
                if (req) state_d = start_st;
            end
            SD_COUNT: begin
                if (req)                    state_d = start_st;
                else if (cnt_q == CNT_LAST) state_d = SD_DONE;
            end
            SD_DONE: begin
                state_d = req ? start_st : SD_IDLE;
            end
            default: state_d = SD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (req)
                cnt_q <= '0;
            else if (state_q == SD_COUNT && cnt_q != CNT_LAST)
                cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        release_o = (state_q == SD_DONE);
    end

    AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o && !req) |=> !release_o); // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SD_COUNT) |-> (cnt_q <= CNT_LAST)); // R11
    AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SD_COUNT && !req && cnt_q != CNT_LAST) |=> !release_o); // R12

endmodule

// File: rtl/sysopt_cfg.sv
`timescale 1ns/1ps
module sysopt_cfg
    import sysopt_pkg::*;
#(
    parameter int WINDOW_CYCLES = 64,
    parameter int STOP_DELAY    = 4096,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       special_mode,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_pin_n,
    input  logic       irq_clr,
    input  logic       stop_exit_req,
    output logic       irq_req,
    output logic       stop_release,
    output logic       ana_pwr_o,
    output logic       clk_sel_o,
    output logic       clkmon_en_o,
    output logic [1:0] wdog_rate_o
);

    logic [7:0] opt_q;
    logic [7:0] wmask;
    logic       wr_hit;
    logic       prot_wr_ok;

    assign wr_hit = reg_sel & reg_wr;

    sysopt_wprot #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) u_wprot (
        .clk         (clk),
        .rst_n       (rst_n),
        .special_mode(special_mode),
        .wr_hit      (wr_hit),
        .prot_wr_ok  (prot_wr_ok)
    );

    always_comb begin
        wmask = FREE_MASK | (prot_wr_ok ? PROT_MASK : 8'h00);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            opt_q <= OPT_RESET;
        else if (wr_hit)
            opt_q <= (opt_q & ~wmask) | (reg_wdata & wmask);
    end

    always_comb begin
        reg_rdata = reg_sel ? opt_q : 8'h00;
    end

    assign ana_pwr_o   = opt_q[BIT_ANA];
    assign clk_sel_o   = opt_q[BIT_CLKSEL];
    assign clkmon_en_o = opt_q[BIT_MON];
    assign wdog_rate_o = {opt_q[BIT_RATE_HI], opt_q[BIT_RATE_LO]};

    sysopt_irq_cond #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (irq_pin_n),
        .edge_mode(opt_q[BIT_EDGE]),
        .clr      (irq_clr),
        .irq_req  (irq_req)
    );

    sysopt_stop_dly #(
        .STOP_DELAY(STOP_DELAY)
    ) u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (stop_exit_req),
        .wait_en  (opt_q[BIT_WAIT]),
        .release_o(stop_release)
    );

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[BIT_HOLE] == 1'b0)); // R2
    AST_PROT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !prot_wr_ok) |=> $stable(opt_q & PROT_MASK)); // R6
    AST_FREE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((opt_q & FREE_MASK) == ($past(reg_wdata) & FREE_MASK))); // R3
    AST_SPECIAL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && special_mode) |=> ((opt_q & PROT_MASK) == ($past(reg_wdata) & PROT_MASK))); // R7

endmodule

// File: tb/sysopt_cfg_bench.sv
`timescale 1ns/1ps
module sysopt_cfg_bench;

    localparam int WIN = 16;
    localparam int DLY = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_pin_n = 1'b1;
    logic       irq_clr = 1'b0;
    logic       stop_exit_req = 1'b0;
    logic       irq_req;
    logic       stop_release;
    logic       ana_pwr_o;
    logic       clk_sel_o;
    logic       clkmon_en_o;
    logic [1:0] wdog_rate_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model;

    always #2.5 clk = ~clk;

    sysopt_cfg #(
        .WINDOW_CYCLES(WIN),
        .STOP_DELAY   (DLY),
        .SYNC_STAGES  (2)
    ) u_sysopt_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_pin_n    (irq_pin_n),
        .irq_clr      (irq_clr),
        .stop_exit_req(stop_exit_req),
        .irq_req      (irq_req),
        .stop_release (stop_release),
        .ana_pwr_o    (ana_pwr_o),
        .clk_sel_o    (clk_sel_o),
        .clkmon_en_o  (clkmon_en_o),
        .wdog_rate_o  (wdog_rate_o)
    );

    function automatic logic [7:0] apply_wr(input logic [7:0] cur, input logic [7:0] d,
                                            input logic prot_ok);
        logic [7:0] m;
        m = 8'hC8 | (prot_ok ? 8'h33 : 8'h00);
        return (cur & ~m) | (d & m);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        special_mode = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        irq_pin_n = 1'b1; irq_clr = 1'b0; stop_exit_req = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
        tick(1);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] exp);
        reg_sel = 1'b1;
        #1;
        chk(tag, reg_rdata, exp);
        reg_sel = 1'b0;
        #1;
    endtask

    task automatic outs_chk(input string tag, input logic [7:0] v);
        chk(tag, {ana_pwr_o, clk_sel_o, clkmon_en_o, wdog_rate_o},
            {v[7], v[6], v[3], v[1:0]});
    endtask

    task automatic stop_pulse();
        stop_exit_req = 1'b1;
        tick(1);
        stop_exit_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));

        // R1 / R2: reset state
        do_reset();
        rd_chk("R1 reset value", 8'h10);
        outs_chk("R1 reset outputs", 8'h10);
        chk("R1 irq idle", irq_req, 1'b0);
        chk("R1 release idle", stop_release, 1'b0);
        #1 chk("R2 unselected read", reg_rdata, 8'h00);

        // R4: last edge of the window, R5: then locked
        do_reset();
        tick(WIN - 1);
        wr(8'hFF);
        rd_chk("R4 last window edge accepted, R2 hole zero", 8'hFB);
        outs_chk("R3 outputs follow", 8'hFB);
        wr(8'h00);
        rd_chk("R5 second write ignored on protected bits", 8'h33);

        // R6: first edge after window
        do_reset();
        tick(WIN);
        wr(8'hFF);
        rd_chk("R6 expired window", 8'hD8);

        // R4 first edge, R5 lock
        do_reset();
        wr(8'h20);
        rd_chk("R4 first edge accepted", 8'h20);
        wr(8'h13);
        rd_chk("R5 locked after first write", 8'h20);
        wr(8'hC8);
        rd_chk("R3 free bits after lock", 8'hE8);

        // R7: special mode, then random mixed
        do_reset();
        special_mode = 1'b1;
        tick(WIN + 5);
        wr(8'h23);
        rd_chk("R7 special write late", 8'h23);
        wr(8'h10);
        rd_chk("R7 special rewrite", 8'h10);
        model = 8'h10;
        for (int i = 0; i < 200; i++) begin
            logic [7:0] d;
            logic       sp;
            d  = 8'($urandom);
            sp = 1'($urandom);
            special_mode = sp;
            wr(d);
            model = apply_wr(model, d, sp);
            rd_chk(sp ? "R7 random special" : "R6 random normal", model);
            outs_chk("R3 random outputs", model);
        end

        // R8: level mode
        special_mode = 1'b1;
        wr(8'h00);
        tick(3);
        irq_pin_n = 1'b0;
        tick(1);
        chk("R8 level after one edge", irq_req, 1'b0);
        tick(1);
        chk("R8 level after two edges", irq_req, 1'b1);
        irq_pin_n = 1'b1;
        tick(2);
        chk("R8 level released", irq_req, 1'b0);

        // R9: edge mode
        wr(8'h20);
        tick(3);
        chk("R9 edge idle", irq_req, 1'b0);
        irq_pin_n = 1'b0;
        tick(2);
        chk("R9 edge not yet", irq_req, 1'b0);
        tick(1);
        chk("R9 edge latched", irq_req, 1'b1);
        irq_pin_n = 1'b1;
        tick(5);
        chk("R9 held after pin high", irq_req, 1'b1);
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        chk("R9 cleared", irq_req, 1'b0);
        irq_pin_n = 1'b0;
        tick(3);
        chk("R9 second edge", irq_req, 1'b1);
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        tick(6);
        chk("R9 held low no retrigger", irq_req, 1'b0);
        irq_pin_n = 1'b1;
        tick(3);

        // R10: immediate release
        wr(8'h00);
        stop_pulse();
        chk("R10 immediate pulse", stop_release, 1'b1);
        tick(1);
        chk("R10 pulse single", stop_release, 1'b0);

        // R11: delayed release
        wr(8'h10);
        stop_pulse();
        for (int k = 1; k <= DLY; k++) begin
            chk("R11 quiet during delay", stop_release, 1'b0);
            tick(1);
        end
        chk("R11 delayed pulse", stop_release, 1'b1);
        tick(1);
        chk("R11 pulse single", stop_release, 1'b0);

        // R12: restart
        stop_pulse();
        tick(19);
        stop_pulse();
        for (int k = 1; k <= DLY; k++) begin
            chk("R12 quiet after restart", stop_release, 1'b0);
            tick(1);
        end
        chk("R12 restarted pulse", stop_release, 1'b1);
        tick(1);
        chk("R12 pulse single", stop_release, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule